// File: doc/BRIEF.md
# ECC Syndrome Checker and Single-Bit Corrector

This block judges the integrity of a flash data chunk of 256 bytes. For each chunk it takes two 22-bit error-check codes: the one computed while the data streamed in, and the one read back from the spare area. Each code arrives as a 24-bit word built little-endian from three bytes, with byte 0 in bits 7:0. Only the low 22 bits carry code; the top two bits are ignored. The block forms the syndrome as the XOR of the two codes. It then sorts the chunk into one of four classes: clean, damage in the code bits only, a single data bit that can be corrected, or uncorrectable.

For a correctable chunk the block returns the index of the failing byte and a one-hot 8-bit mask. The caller XORs the mask into that byte. The number of chunks is a parameter. With two lanes, both halves of a 512-byte page are judged in the same pass, and a single fail flag is the OR of the per-lane failures. A one-cycle start strobe launches a check. Exactly two cycles later a one-cycle done pulse marks the results, and the results hold until the next check.

Top module: `ecc_syn_checker`

## Requirements
- R1: When the low 22 bits of the calculated and stored codes are equal, the lane's status is clean (code 2'b00).
- R2: When the low 22 bits of either code are all zero, the lane's status is clean (2'b00), whatever the other code holds.
- R3: When the syndrome has exactly one bit set (and neither code is zero), the status is code-bits error (2'b01), the data is left alone, and the lane counts as failed.
- R4: When the syndrome has exactly 11 bits set and, for every i in 0..10, syndrome bit i differs from syndrome bit i+11, the status is corrected (2'b10). The byte index is syndrome bits 10:3 and the mask is 1 shifted left by syndrome bits 2:0.
- R5: Any other nonzero syndrome is uncorrectable (2'b11) and counts as failed. This includes 11 set bits without the pairing.
- R6: For every status other than corrected, the lane's byte index and bit mask are zero; the mask always has at most one bit set.
- R7: Done rises exactly two clock cycles after a one-cycle start, lasts one cycle, and the results stay unchanged while done is low.
- R8: Bits 23:22 of each 24-bit code word have no effect on the result.
- R9: Lane k reads code bits [24k+23:24k]; fail equals the OR over lanes of (status is 2'b01 or 2'b11).
- R10: During and right after synchronous reset, done, fail, status, byte index and mask are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe that samples the codes |
| calc_code | input | 24*NUM_CHUNKS | Calculated codes, 24 bits per lane |
| stored_code | input | 24*NUM_CHUNKS | Codes read from the spare area, 24 bits per lane |
| done | output | 1 | One-cycle pulse when results are valid |
| status | output | 2*NUM_CHUNKS | Per-lane class: 00 clean, 01 code error, 10 corrected, 11 uncorrectable |
| byte_idx | output | 8*NUM_CHUNKS | Per-lane failing byte index |
| bit_mask | output | 8*NUM_CHUNKS | Per-lane one-hot correction mask |
| fail | output | 1 | OR of lane failures |

## Verification
The bench builds the checker with NUM_CHUNKS set to 2 and the other parameters at their defaults. This places a different class on each lane within one pass, which exposes lane-slicing mistakes and a wrong fail merge. Correctable syndromes are generated from chosen locations at both ends of the byte and bit range. An 11-bit syndrome that lacks the pairing reaches the uncorrectable path. Upper-bit and zero-code cases exercise the masking of the top two bits and the zero-code override.

// File: rtl/ecc_syn_pkg.sv
// Shared types for the ECC syndrome checker.
// Assumes: the class codes below are visible at the top-level status port.
package ecc_syn_pkg;

    // Outcome of one chunk check; bit 0 set marks a failing chunk.
    typedef enum logic [1:0] {
        ECC_CLEAN    = 2'b00,
        ECC_CODE_ERR = 2'b01,
        ECC_FIXED    = 2'b10,
        ECC_FATAL    = 2'b11
    } ecc_class_e;

endpackage

// File: rtl/ecc_syn_front.sv
// First stage of one lane: masks the code words to their meaningful bits,
// forms the syndrome, flags the zero cases, evaluates the true/complement
// pairing and counts syndrome ones. Everything is registered on load.
// Assumes: load is a single-cycle strobe; the upper word bits are don't-care.
module ecc_syn_front #(
    parameter int HALF_W = 11,
    parameter int WORD_W = 24
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic [WORD_W-1:0]                 calc_word,
    input  logic [WORD_W-1:0]                 stored_word,
    output logic [2*HALF_W-1:0]               s1_syn,
    output logic                              s1_skip,
    output logic                              s1_pair,
    output logic [$clog2(2*HALF_W+1)-1:0]     s1_cnt
);
    localparam int CODE_W = 2 * HALF_W;
    localparam int CNT_W  = $clog2(CODE_W + 1);

    logic [CODE_W-1:0] calc_m;
    logic [CODE_W-1:0] stored_m;
    logic [CODE_W-1:0] syn_c;
    logic [HALF_W-1:0] fold_c;
    logic              skip_c;
    logic              pair_c;
    logic [CNT_W-1:0]  cnt_c;

    // Purpose: derive syndrome, zero flags and the pairing fold.
    always_comb begin
        calc_m   = calc_word[CODE_W-1:0];
        stored_m = stored_word[CODE_W-1:0];
        syn_c    = calc_m ^ stored_m;
        skip_c   = (syn_c == '0) || (calc_m == '0) || (stored_m == '0);
        fold_c   = calc_m[HALF_W-1:0] ^ calc_m[CODE_W-1:HALF_W]
                 ^ stored_m[HALF_W-1:0] ^ stored_m[CODE_W-1:HALF_W];
        pair_c   = (fold_c == {HALF_W{1'b1}});
    end

    // Purpose: population count of the syndrome.
    always_comb begin
        cnt_c = '0;
        for (int i = 0; i < CODE_W; i++) begin
            cnt_c = cnt_c + CNT_W'(syn_c[i]);
        end
    end

    // Purpose: capture stage-one results when a check is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_syn  <= '0;
            s1_skip <= 1'b1;
            s1_pair <= 1'b0;
            s1_cnt  <= '0;
        end else if (load) begin
            s1_syn  <= syn_c;
            s1_skip <= skip_c;
            s1_pair <= pair_c;
            s1_cnt  <= cnt_c;
        end
    end

endmodule

// File: rtl/ecc_syn_classify.sv
// Second stage of one lane: turns the stage-one flags into a class and,
// for a correctable chunk, into a byte index and one-hot bit mask.
// Assumes: load pulses one cycle after the stage-one capture.
module ecc_syn_classify
    import ecc_syn_pkg::*;
#(
    parameter int HALF_W    = 11,
    parameter int BIT_SEL_W = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load,
    input  logic [2*HALF_W-1:0]                 s1_syn,
    input  logic                                s1_skip,
    input  logic                                s1_pair,
    input  logic [$clog2(2*HALF_W+1)-1:0]       s1_cnt,
    output ecc_class_e                          cls,
    output logic [HALF_W-BIT_SEL_W-1:0]         idx,
    output logic [(1<<BIT_SEL_W)-1:0]           mask
);
    localparam int CNT_W  = $clog2(2 * HALF_W + 1);
    localparam int IDX_W  = HALF_W - BIT_SEL_W;
    localparam int MASK_W = 1 << BIT_SEL_W;

    ecc_class_e        cls_c;
    logic [IDX_W-1:0]  idx_c;
    logic [MASK_W-1:0] mask_c;

    // Purpose: priority decision over the syndrome classes.
    always_comb begin
        if (s1_skip) begin
            cls_c = ECC_CLEAN;
        end else if (s1_cnt == CNT_W'(1)) begin
            cls_c = ECC_CODE_ERR;
        end else if ((s1_cnt == CNT_W'(HALF_W)) && s1_pair) begin
            cls_c = ECC_FIXED;
        end else begin
            cls_c = ECC_FATAL;
        end
    end

    // Purpose: location outputs, forced to zero unless correctable.
    always_comb begin
        idx_c  = '0;
        mask_c = '0;
        if (cls_c == ECC_FIXED) begin
            idx_c  = s1_syn[HALF_W-1:BIT_SEL_W];
            mask_c = MASK_W'(1) << s1_syn[BIT_SEL_W-1:0];
        end
    end

    // Purpose: register the lane result and hold it until the next check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls  <= ECC_CLEAN;
            idx  <= '0;
            mask <= '0;
        end else if (load) begin
            cls  <= cls_c;
            idx  <= idx_c;
            mask <= mask_c;
        end
    end

endmodule

// File: rtl/ecc_syn_checker.sv
// Top of the ECC syndrome checker: NUM_CHUNKS parallel lanes, each a
// front stage and a classify stage, sharing a two-deep valid pipeline.
// Assumes: start is one cycle wide; codes are stable in the start cycle.
module ecc_syn_checker
    import ecc_syn_pkg::*;
#(
    parameter int NUM_CHUNKS = 1,
    parameter int HALF_W     = 11,
    parameter int BIT_SEL_W  = 3,
    parameter int WORD_W     = 24
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         start,
    input  logic [NUM_CHUNKS*WORD_W-1:0]                 calc_code,
    input  logic [NUM_CHUNKS*WORD_W-1:0]                 stored_code,
    output logic                                         done,
    output logic [2*NUM_CHUNKS-1:0]                      status,
    output logic [NUM_CHUNKS*(HALF_W-BIT_SEL_W)-1:0]     byte_idx,
    output logic [NUM_CHUNKS*(1<<BIT_SEL_W)-1:0]         bit_mask,
    output logic                                         fail
);
    localparam int CODE_W = 2 * HALF_W;
    localparam int CNT_W  = $clog2(CODE_W + 1);
    localparam int IDX_W  = HALF_W - BIT_SEL_W;
    localparam int MASK_W = 1 << BIT_SEL_W;

    logic                  stage1_vld;
    logic [NUM_CHUNKS-1:0] lane_fail;

    // Purpose: two-deep valid pipeline producing the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_vld <= 1'b0;
            done       <= 1'b0;
        end else begin
            stage1_vld <= start;
            done       <= stage1_vld;
        end
    end

    for (genvar k = 0; k < NUM_CHUNKS; k++) begin : g_lane
        logic [CODE_W-1:0] syn;
        logic              skip;
        logic              pair;
        logic [CNT_W-1:0]  cnt;
        ecc_class_e        cls;

        ecc_syn_front #(
            .HALF_W (HALF_W),
            .WORD_W (WORD_W)
        ) u_front (
            .clk         (clk),
            .rst_n       (rst_n),
            .load        (start),
            .calc_word   (calc_code[k*WORD_W +: WORD_W]),
            .stored_word (stored_code[k*WORD_W +: WORD_W]),
            .s1_syn      (syn),
            .s1_skip     (skip),
            .s1_pair     (pair),
            .s1_cnt      (cnt)
        );

        ecc_syn_classify #(
            .HALF_W    (HALF_W),
            .BIT_SEL_W (BIT_SEL_W)
        ) u_cls (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (stage1_vld),
            .s1_syn  (syn),
            .s1_skip (skip),
            .s1_pair (pair),
            .s1_cnt  (cnt),
            .cls     (cls),
            .idx     (byte_idx[k*IDX_W +: IDX_W]),
            .mask    (bit_mask[k*MASK_W +: MASK_W])
        );

        // Purpose: expose the class and mark failing lanes.
        always_comb begin
            status[2*k +: 2] = cls;
            lane_fail[k]     = (cls == ECC_CODE_ERR) || (cls == ECC_FATAL);
        end
    end

    // Purpose: merge lane failures into one flag.
    always_comb begin
        fail = |lane_fail;
    end

endmodule

// File: rtl/ecc_syn_checker_sva.sv
// Assertion checker for ecc_syn_checker, attached by bind below.
// Assumes: the same parameter values as the bound instance.
module ecc_syn_checker_sva #(
    parameter int NUM_CHUNKS = 1,
    parameter int HALF_W     = 11,
    parameter int BIT_SEL_W  = 3,
    parameter int WORD_W     = 24
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic                                     start,
    input logic [NUM_CHUNKS*WORD_W-1:0]             calc_code,
    input logic [NUM_CHUNKS*WORD_W-1:0]             stored_code,
    input logic                                     done,
    input logic [2*NUM_CHUNKS-1:0]                  status,
    input logic [NUM_CHUNKS*(HALF_W-BIT_SEL_W)-1:0] byte_idx,
    input logic [NUM_CHUNKS*(1<<BIT_SEL_W)-1:0]     bit_mask,
    input logic                                     fail
);
    localparam int CODE_W = 2 * HALF_W;
    localparam int IDX_W  = HALF_W - BIT_SEL_W;
    localparam int MASK_W = 1 << BIT_SEL_W;

    logic any_fail;

    // Purpose: reference OR of the per-lane failing classes.
    always_comb begin
        any_fail = 1'b0;
        for (int k = 0; k < NUM_CHUNKS; k++) begin
            any_fail = any_fail | status[2*k];
        end
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##2 done); // R7

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 2)); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(status) && $stable(byte_idx) && $stable(bit_mask))); // R7

    AST_FAIL_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        fail == any_fail); // R9

    AST_EQUAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(calc_code[CODE_W-1:0] == stored_code[CODE_W-1:0], 2))
        |-> (status[1:0] == 2'b00)); // R1

    for (genvar k = 0; k < NUM_CHUNKS; k++) begin : g_lane_chk
        AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(bit_mask[k*MASK_W +: MASK_W])); // R6

        AST_LOC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (status[2*k +: 2] != 2'b10)
            |-> (bit_mask[k*MASK_W +: MASK_W] == '0 && byte_idx[k*IDX_W +: IDX_W] == '0)); // R6

        AST_FIXED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            (status[2*k +: 2] == 2'b10)
            |-> ($countones(bit_mask[k*MASK_W +: MASK_W]) == 1)); // R4
    end

endmodule

bind ecc_syn_checker ecc_syn_checker_sva #(
    .NUM_CHUNKS (NUM_CHUNKS),
    .HALF_W     (HALF_W),
    .BIT_SEL_W  (BIT_SEL_W),
    .WORD_W     (WORD_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .calc_code   (calc_code),
    .stored_code (stored_code),
    .done        (done),
    .status      (status),
    .byte_idx    (byte_idx),
    .bit_mask    (bit_mask),
    .fail        (fail)
);

// File: tb/tb_ecc_syn_checker.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, zero codes, ignored upper bits and result hold.
module tb_ecc_syn_checker;
    localparam int N = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [47:0]   calc_code = '0;
    logic [47:0]   stored_code = '0;
    logic          done;
    logic [3:0]    status;
    logic [15:0]   byte_idx;
    logic [15:0]   bit_mask;
    logic          fail;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ecc_syn_checker #(.NUM_CHUNKS(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .calc_code(calc_code), .stored_code(stored_code),
        .done(done), .status(status), .byte_idx(byte_idx),
        .bit_mask(bit_mask), .fail(fail)
    );

    typedef struct packed {
        logic [23:0] c0;
        logic [23:0] syn0;
        logic [23:0] c1;
        logic [23:0] syn1;
        logic [1:0]  st0;
        logic [7:0]  ix0;
        logic [7:0]  mk0;
        logic [1:0]  st1;
        logic [7:0]  ix1;
        logic [7:0]  mk1;
        logic        fl;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{24'h155555, 24'h000000, 24'h0ABCDE, 24'h000000, 2'd0, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b0},
        '{24'h155555, 24'h000001, 24'h0ABCDE, 24'h000000, 2'd1, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b1},
        '{24'h155555, 24'h3AD0A5, 24'h0ABCDE, 24'h0007FF, 2'd2, 8'h14, 8'h20, 2'd2, 8'hFF, 8'h80, 1'b0},
        '{24'h155555, 24'h3FF800, 24'h0ABCDE, 24'h200000, 2'd2, 8'h00, 8'h01, 2'd1, 8'h00, 8'h00, 1'b1},
        '{24'h155555, 24'h000003, 24'h0ABCDE, 24'h00F83F, 2'd3, 8'h00, 8'h00, 2'd3, 8'h00, 8'h00, 1'b1},
        '{24'h155555, 24'h3FFFFF, 24'h0ABCDE, 24'h000400, 2'd3, 8'h00, 8'h00, 2'd1, 8'h00, 8'h00, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Launch one check and compare lane results at the done cycle.
    task automatic run_case(input logic [23:0] c0, input logic [23:0] s0,
                            input logic [23:0] c1, input logic [23:0] s1,
                            input logic [1:0] st0, input logic [7:0] ix0, input logic [7:0] mk0,
                            input logic [1:0] st1, input logic [7:0] ix1, input logic [7:0] mk1,
                            input logic fl, input string req);
        @(negedge clk);
        calc_code   = {c1, c0};
        stored_code = {s1, s0};
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R7 early done", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R7 done", done, 1);
        chk(status[1:0] == st0 && byte_idx[7:0] == ix0 && bit_mask[7:0] == mk0,
            {req, " lane0"}, {status[1:0], byte_idx[7:0], bit_mask[7:0]}, {st0, ix0, mk0});
        chk(status[3:2] == st1 && byte_idx[15:8] == ix1 && bit_mask[15:8] == mk1,
            {req, " lane1 R9"}, {status[3:2], byte_idx[15:8], bit_mask[15:8]}, {st1, ix1, mk1});
        chk(fail == fl, "R9 fail merge", fail, fl);
        @(negedge clk);
        chk(done == 1'b0, "R7 single pulse", done, 0);
        chk(status == {st1, st0} && bit_mask == {mk1, mk0}, "R7 hold",
            {status, bit_mask}, {st1, st0, mk1, mk0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(done == 0 && fail == 0 && status == 0 && byte_idx == 0 && bit_mask == 0,
            "R10 reset", {done, fail, status, byte_idx, bit_mask}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 0 && status == 0 && bit_mask == 0, "R10 after reset",
            {done, status, bit_mask}, 0);

        // Table: R1 clean, R3 code error, R4 corrected, R5 uncorrectable, R6 zero location
        for (int i = 0; i < 6; i++) begin
            run_case(VECS[i].c0, VECS[i].c0 ^ VECS[i].syn0,
                     VECS[i].c1, VECS[i].c1 ^ VECS[i].syn1,
                     VECS[i].st0, VECS[i].ix0, VECS[i].mk0,
                     VECS[i].st1, VECS[i].ix1, VECS[i].mk1,
                     VECS[i].fl, "R1/R3/R4/R5/R6 table");
        end

        // R2: a zero calculated code in lane 0, a zero stored code in lane 1
        run_case(24'hC00000, 24'h123456, 24'h0ABCDE, 24'h000000,
                 2'd0, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b0, "R2 zero code");

        // R8: upper bits differ but low 22 bits match
        run_case(24'hD55555, 24'h155555, 24'h800001, 24'h000001,
                 2'd0, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b0, "R8 upper bits");

        // R8: upper bits set on a correctable case leave the location untouched
        run_case(24'hC00000 | 24'h155555, 24'h2F85F0, 24'h0ABCDE, 24'h0ABCDE,
                 2'd2, 8'h14, 8'h20, 2'd0, 8'h00, 8'h00, 1'b0, "R8 R4 upper bits");

        // R7: results stay put across idle cycles
        repeat (4) @(negedge clk);
        chk(done == 0 && status == 4'b0010 && bit_mask == 16'h0020, "R7 idle hold",
            {done, status, bit_mask}, {1'b0, 4'b0010, 16'h0020});

        // R10: reset clears held results
        rst_n = 1'b0;
        @(negedge clk);
        chk(status == 0 && bit_mask == 0 && byte_idx == 0 && fail == 0, "R10 re-reset",
            {status, bit_mask, byte_idx, fail}, 0);
        rst_n = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule